// File: doc/BRIEF.md
# Sleep and Idle Power Controller

This block decides which clocks of a small processor subsystem run. In Run everything is clocked. The processor can ask for one of two low-power modes through a single command strobe. Sleep turns off the system oscillator and every clock derived from it. Idle stops only the processor clock, so the peripherals keep working. Either mode ends and the block returns to Run when an enabled interrupt is pending, when the built-in watchdog expires, or when reset is applied.

The watchdog is a plain counter. It advances on ticks from the low-power RC oscillator, and its enable also keeps that oscillator running. When the processor enters Sleep with the watchdog enabled, the counter restarts and a clear pulse is issued. While the system clock is off, the clock monitor enable is dropped. The clock-source selection register accepts writes only in Run, so the source that was active when Sleep began is still selected after wake-up.

All enables are flip-flop outputs of one free-running control clock. A gated clock therefore never sees its enable change between edges.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is asserted and after it is released, mode_status reads Run (2'b00), cpu_clk_en, periph_clk_en, osc_en and clkmon_en are 1, and wdt_clr_pulse, wdt_timeout and lprc_en are 0. Reset also removes any low-power mode in progress.
- R2: A request (mode_req_vld=1, mode_req_sleep=1) sampled in Run with no wake condition puts the block in Sleep at that edge. mode_status then reads 2'b10, and cpu_clk_en, periph_clk_en, osc_en and clkmon_en are all 0.
- R3: A request with mode_req_sleep=0 under the same conditions puts the block in Idle. mode_status reads 2'b01, cpu_clk_en is 0, and periph_clk_en, osc_en and clkmon_en stay 1.
- R4: In Sleep or Idle, if any line has both irq_pend and irq_en set, the block is back in Run after the next edge and all four clock enables are 1 again.
- R5: A pending interrupt whose enable is 0 does not end Sleep or Idle.
- R6: With wdt_en=1, wdt_timeout is a one-cycle pulse after WDT_LIMIT lprc_tick samples counted since the last clear. A timeout seen in Sleep or Idle returns the block to Run at the next edge.
- R7: Entering Sleep with wdt_en=1 gives a one-cycle wdt_clr_pulse whose high cycle is the first Sleep cycle, and the watchdog count restarts from zero at that edge. Entering Sleep with wdt_en=0 gives no pulse.
- R8: lprc_en follows wdt_en one edge later in every mode, so during Sleep the low-power oscillator runs only while the watchdog is enabled.
- R9: A request sampled while a wake condition is true is ignored, and the block stays in Run. A request sampled in Idle or Sleep is also ignored.
- R10: clk_src_sel takes clk_src_din on an edge with clk_src_wr=1 only when the block is in Run. A write in Sleep or Idle has no effect, so the source that was selected at entry is still selected after wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_req_vld | input | 1 | Low-power mode command strobe |
| mode_req_sleep | input | 1 | 1 requests Sleep, 0 requests Idle |
| irq_pend | input | N_IRQ | Pending flag per interrupt line |
| irq_en | input | N_IRQ | Enable per interrupt line |
| wdt_en | input | 1 | Watchdog enable |
| wdt_kick | input | 1 | Software clear of the watchdog count |
| lprc_tick | input | 1 | One tick of the low-power oscillator, synchronised to clk |
| clk_src_wr | input | 1 | Write strobe for the clock-source register |
| clk_src_din | input | SRC_W | New clock-source code |
| mode_status | output | 2 | 00 Run, 01 Idle, 10 Sleep |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | System oscillator enable |
| lprc_en | output | 1 | Low-power RC oscillator enable |
| clkmon_en | output | 1 | Clock monitor enable |
| wdt_clr_pulse | output | 1 | Watchdog cleared on Sleep entry |
| wdt_timeout | output | 1 | Watchdog expiry pulse |
| clk_src_sel | output | SRC_W | Current clock-source selection |

## Verification
The hardest case to reach is a watchdog wake from Sleep that proves the count restarted on entry. The stimulus first sends ticks in Run so that the counter holds a nonzero value. It then requests Sleep, counts exactly WDT_LIMIT-1 further ticks and checks that no timeout or wake has happened yet. The last tick must give the pulse, and Run must follow one edge later. A second hard case is a request that arrives together with a live enabled interrupt: both are driven in the same cycle, and the bench checks that the status stays Run.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_SLEEP = 2'b10
  } pm_state_t;

  // Clock-gate pattern per mode, ordered {cpu, periph, osc, clkmon}
  function automatic logic [3:0] pm_gates(pm_state_t s);
    case (s)
      PM_IDLE:  return 4'b0111;
      PM_SLEEP: return 4'b0000;
      default:  return 4'b1111;
    endcase
  endfunction

  // Mode transition: requests only from Run, wake always wins
  function automatic pm_state_t pm_next(pm_state_t cur, logic req_vld,
                                        logic req_sleep, logic wake);
    pm_state_t n;
    n = cur;
    if (cur == PM_RUN) begin
      if (req_vld && !wake) n = req_sleep ? PM_SLEEP : PM_IDLE;
    end else if (wake) begin
      n = PM_RUN;
    end
    return n;
  endfunction

  // Watchdog terminal test
  function automatic logic wdt_at_end(int unsigned cnt, int unsigned limit);
    return cnt == (limit - 1);
  endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_to,
  output logic             wake
);
  logic [N_IRQ-1:0] line_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign line_hit[i] = irq_pend[i] & irq_en[i];
  end

  assign wake = (|line_hit) | wdt_to;

  always_comb begin
    if (!(|irq_en)) a_no_en_wake_r5: assert (wake == wdt_to);
  end
endmodule

// File: rtl/pwr_wdt.sv
module pwr_wdt
  import pwr_mode_pkg::*;
#(
  parameter int WDT_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_en,
  input  logic tick,
  input  logic clr,
  output logic timeout,
  output logic lprc_en
);
  localparam int CW = (WDT_LIMIT < 2) ? 1 : $clog2(WDT_LIMIT);

  logic [CW-1:0] cnt_q;
  logic          to_q;
  logic          lprc_q;
  logic          hit_end;

  assign hit_end = wdt_at_end(int'(cnt_q), WDT_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      to_q   <= 1'b0;
      lprc_q <= 1'b0;
    end else begin
      lprc_q <= wdt_en;
      if (clr || !wdt_en) begin
        cnt_q <= '0;
        to_q  <= 1'b0;
      end else if (tick) begin
        to_q  <= hit_end;
        cnt_q <= hit_end ? '0 : cnt_q + 1'b1;
      end else begin
        to_q <= 1'b0;
      end
    end
  end

  assign timeout = to_q;
  assign lprc_en = lprc_q;

  p_to_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |=> !to_q);
  p_lprc_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_en |=> lprc_q);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_vld,
  input  logic      req_sleep,
  input  logic      wake,
  input  logic      wdt_en,
  output pm_state_t state,
  output logic      sleep_entry,
  output logic      wdt_clr_pulse,
  output logic      cpu_en,
  output logic      periph_en,
  output logic      osc_en,
  output logic      clkmon_en
);
  pm_state_t  st_q, st_d;
  logic [3:0] gate_q;
  logic       clr_q;

  assign st_d        = pm_next(st_q, req_vld, req_sleep, wake);
  assign sleep_entry = (st_q == PM_RUN) && (st_d == PM_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PM_RUN;
      gate_q <= 4'b1111;
      clr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      gate_q <= pm_gates(st_d);
      clr_q  <= sleep_entry && wdt_en;
    end
  end

  assign state         = st_q;
  assign wdt_clr_pulse = clr_q;
  assign cpu_en        = gate_q[3];
  assign periph_en     = gate_q[2];
  assign osc_en        = gate_q[1];
  assign clkmon_en     = gate_q[0];

  p_sleep_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_SLEEP) |-> (!cpu_en && !periph_en && !osc_en && !clkmon_en));
  p_idle_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_IDLE) |-> (!cpu_en && periph_en && osc_en && clkmon_en));
  p_wake_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PM_RUN && wake) |=> (st_q == PM_RUN));
  p_no_wake_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PM_RUN && !wake) |=> $stable(st_q));
  p_clr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
  p_clr_in_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> (st_q == PM_SLEEP));
  p_req_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_RUN && wake) |=> (st_q == PM_RUN));
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ     = 8,
  parameter int WDT_LIMIT = 16,
  parameter int SRC_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_req_vld,
  input  logic             mode_req_sleep,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             wdt_en,
  input  logic             wdt_kick,
  input  logic             lprc_tick,
  input  logic             clk_src_wr,
  input  logic [SRC_W-1:0] clk_src_din,
  output logic [1:0]       mode_status,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             lprc_en,
  output logic             clkmon_en,
  output logic             wdt_clr_pulse,
  output logic             wdt_timeout,
  output logic [SRC_W-1:0] clk_src_sel
);
  pm_state_t        state;
  logic             wake;
  logic             sleep_entry;
  logic             wdt_clr_int;
  logic [SRC_W-1:0] src_q;

  assign wdt_clr_int = wdt_kick | sleep_entry;

  pwr_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .wdt_to   (wdt_timeout),
    .wake     (wake)
  );

  pwr_wdt #(.WDT_LIMIT(WDT_LIMIT)) u_wdt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdt_en  (wdt_en),
    .tick    (lprc_tick),
    .clr     (wdt_clr_int),
    .timeout (wdt_timeout),
    .lprc_en (lprc_en)
  );

  pwr_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_vld       (mode_req_vld),
    .req_sleep     (mode_req_sleep),
    .wake          (wake),
    .wdt_en        (wdt_en),
    .state         (state),
    .sleep_entry   (sleep_entry),
    .wdt_clr_pulse (wdt_clr_pulse),
    .cpu_en        (cpu_clk_en),
    .periph_en     (periph_clk_en),
    .osc_en        (osc_en),
    .clkmon_en     (clkmon_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              src_q <= '0;
    else if (clk_src_wr && state == PM_RUN) src_q <= clk_src_din;
  end

  assign clk_src_sel = src_q;
  assign mode_status = state;

  p_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PM_RUN) |=> $stable(clk_src_sel));
endmodule

// File: tb/sim_pwr_mode_ctl.sv
module sim_pwr_mode_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ      = 8;
  localparam int WDT_LIM    = 16;
  localparam int SRC_W      = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_req_vld = 1'b0, mode_req_sleep = 1'b0;
  logic [N_IRQ-1:0] irq_pend = '0, irq_en = '0;
  logic             wdt_en = 1'b0, wdt_kick = 1'b0, lprc_tick = 1'b0;
  logic             clk_src_wr = 1'b0;
  logic [SRC_W-1:0] clk_src_din = '0;
  logic [1:0]       mode_status;
  logic             cpu_clk_en, periph_clk_en, osc_en, lprc_en, clkmon_en;
  logic             wdt_clr_pulse, wdt_timeout;
  logic [SRC_W-1:0] clk_src_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl #(.N_IRQ(N_IRQ), .WDT_LIMIT(WDT_LIM), .SRC_W(SRC_W)) u0 (
    .clk, .rst_n, .mode_req_vld, .mode_req_sleep, .irq_pend, .irq_en,
    .wdt_en, .wdt_kick, .lprc_tick, .clk_src_wr, .clk_src_din,
    .mode_status, .cpu_clk_en, .periph_clk_en, .osc_en, .lprc_en,
    .clkmon_en, .wdt_clr_pulse, .wdt_timeout, .clk_src_sel
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // gate bits {cpu, periph, osc, clkmon}
  function automatic int gates();
    return {cpu_clk_en, periph_clk_en, osc_en, clkmon_en};
  endfunction

  task automatic request(bit sleep);
    mode_req_vld = 1'b1; mode_req_sleep = sleep;
    step();
    mode_req_vld = 1'b0;
  endtask

  task automatic wake_by_line(int ln);
    irq_pend[ln] = 1'b1; irq_en[ln] = 1'b1;
    step();
    irq_pend = '0; irq_en = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", mode_status, 0);
    chk("R1 gates", gates(), 15);
    chk("R1 clr/to/lprc", {wdt_clr_pulse, wdt_timeout, lprc_en}, 0);
  endtask

  task automatic t_sleep_irq();
    request(1'b1);
    chk("R2 status", mode_status, 2);
    chk("R2 gates", gates(), 0);
    chk("R7 no clr when wdt off", wdt_clr_pulse, 0);
    irq_pend[3] = 1'b1; irq_en = 8'hF7;
    repeat (3) step();
    chk("R5 masked pending stays asleep", mode_status, 2);
    irq_en[3] = 1'b1;
    step();
    chk("R4 status after wake", mode_status, 0);
    chk("R4 gates after wake", gates(), 15);
    irq_pend = '0; irq_en = '0;
  endtask

  task automatic t_idle_irq();
    request(1'b0);
    chk("R3 status", mode_status, 1);
    chk("R3 gates", gates(), 7);
    irq_pend[0] = 1'b1;
    step();
    chk("R5 idle unmasked none", mode_status, 1);
    irq_pend = '0;
    wake_by_line(0);
    chk("R4 idle wake", mode_status, 0);
    chk("R4 idle gates", gates(), 15);
  endtask

  task automatic t_req_blocked();
    irq_pend[6] = 1'b1; irq_en[6] = 1'b1;
    request(1'b1);
    chk("R9 request under wake", mode_status, 0);
    irq_pend = '0; irq_en = '0;
    request(1'b0);
    request(1'b1);
    chk("R9 request in idle ignored", mode_status, 1);
    wake_by_line(7);
    chk("R9 back to run", mode_status, 0);
  endtask

  task automatic t_wdt_sleep();
    wdt_en = 1'b1;
    step();
    chk("R8 lprc on", lprc_en, 1);
    lprc_tick = 1'b1;
    repeat (5) step();
    lprc_tick = 1'b0;
    request(1'b1);
    chk("R7 sleep status", mode_status, 2);
    chk("R7 clr pulse", wdt_clr_pulse, 1);
    chk("R8 lprc kept in sleep", lprc_en, 1);
    lprc_tick = 1'b1;
    step();
    chk("R7 clr one cycle", wdt_clr_pulse, 0);
    repeat (WDT_LIM - 2) step();
    chk("R6 no early timeout", wdt_timeout, 0);
    chk("R6 still asleep", mode_status, 2);
    step();
    chk("R6 timeout pulse", wdt_timeout, 1);
    lprc_tick = 1'b0;
    step();
    chk("R6 wake on timeout", mode_status, 0);
    chk("R6 pulse ends", wdt_timeout, 0);
    wdt_en = 1'b0;
    step();
  endtask

  task automatic t_lprc_off();
    chk("R8 lprc off", lprc_en, 0);
    request(1'b1);
    chk("R8 lprc off in sleep", lprc_en, 0);
    wake_by_line(2);
  endtask

  task automatic t_src();
    clk_src_wr = 1'b1; clk_src_din = 3'd5;
    step();
    clk_src_wr = 1'b0;
    chk("R10 write in run", clk_src_sel, 5);
    request(1'b1);
    clk_src_wr = 1'b1; clk_src_din = 3'd2;
    step();
    clk_src_wr = 1'b0;
    chk("R10 write in sleep ignored", clk_src_sel, 5);
    wake_by_line(1);
    chk("R10 held after wake", clk_src_sel, 5);
    clk_src_wr = 1'b1;
    step();
    clk_src_wr = 1'b0;
    chk("R10 write after wake", clk_src_sel, 2);
  endtask

  task automatic t_reset_mid();
    request(1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1 reset leaves sleep", mode_status, 0);
    chk("R1 reset gates", gates(), 15);
    step();
    rst_n = 1'b1;
    step();
    chk("R1 run after release", mode_status, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_sleep_irq();
    t_idle_irq();
    t_req_blocked();
    t_wdt_sleep();
    t_lprc_off();
    t_src();
    t_reset_mid();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule